// File: doc/BRIEF.md
# Phase-Accumulator Waveform Synthesizer

This block produces a periodic 8-bit waveform for a parallel resistor-ladder DAC. A 32-bit phase register advances by a programmable tuning word on every sample step. The upper byte of the phase either indexes a built-in cosine table (sine mode) or is sent out unchanged (sawtooth mode). The output frequency is tuning_word * f_sample / 2^32, so one step of frequency resolution equals f_sample / 2^32.

A free-running pacer is built from a divide-by-9 stage followed by a divide-by-2 stage. It opens one sample slot every 18 clocks. A slot becomes a sample step only when the downstream sample FIFO is requesting data. In every other slot the phase and the output hold their values. Software writes the tuning word into a shadow register through a write strobe. The next step then uses that value as a whole. The cosine table is computed at elaboration time with integer arithmetic and needs no initialisation file.

Top module: `dds_synth`

## Requirements
- R1: On each sample step the phase register becomes its old value plus the tuning word, modulo 2^32. Between steps the phase does not change.
- R2: The table index is phase bits [31:24], the most significant byte.
- R3: Table entry i (0..255) equals floor((cos(2*pi*i/256) + 1) * 127). A value less than 1e-6 below an integer counts as that integer. Entries span 0 to 254.
- R4: When `saw_mode` is 1 at a step, `smp_data` becomes phase bits [31:24]. When it is 0, `smp_data` becomes the table entry (sine mode).
- R5: A sample slot occurs once every 18 clocks. With `smp_req` held high, `smp_valid` pulses for exactly one cycle every 18 clocks. The first pulse appears on the 18th rising edge after reset is released.
- R6: A slot in which `smp_req` is low produces no step. `smp_valid` stays low, and both `smp_data` and the phase hold their values.
- R7: A value written with `tw_we` is captured whole into the shadow register. It is used from the next sample step on.
- R8: A synchronous, active-high `rst` clears the phase, the tuning word, both divider counters, `smp_valid` and `smp_data` to zero.
- R9: With a tuning word of zero, every step outputs the same value: the one that belongs to the current phase.
- R10: A step outputs the value for the phase before that step's addition. The first sine sample after reset is therefore 254, and the first sawtooth sample is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tw_we | input | 1 | Write strobe for the tuning word |
| tw_data | input | 32 | Tuning word value to capture |
| saw_mode | input | 1 | 1 = sawtooth (table bypassed), 0 = sine |
| smp_req | input | 1 | Downstream FIFO requests a sample |
| smp_valid | output | 1 | One-cycle pulse marking a new sample |
| smp_data | output | 8 | Sample to the DAC, bit 7 most significant |

## Verification
The assertions assume that reset is asserted from time zero for at least two clocks. They also assume that `smp_req` and `saw_mode` always hold a known level, because each step's result is related to the request and mode seen in the cycle before. The stimulus keeps within this. It writes a new tuning word and changes the mode only in the cycle right after a step, well before the next slot. It drops the request only across whole slots, so the phase model in the bench advances exactly once per observed pulse.

// File: rtl/dds_synth_pkg.sv
package dds_synth_pkg;
    localparam int PHASE_BITS  = 32;
    localparam int SAMPLE_BITS = 8;
    localparam int PRE_DIV     = 9;
    localparam int POST_DIV    = 2;

    typedef enum logic {
        WAVE_SINE = 1'b0,
        WAVE_SAW  = 1'b1
    } wave_t;
endpackage

// File: rtl/dds_synth_pacer.sv
module dds_synth_pacer #(
    parameter int DIV_A = 9,
    parameter int DIV_B = 2
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int AW = (DIV_A > 1) ? $clog2(DIV_A) : 1;
    localparam int BW = (DIV_B > 1) ? $clog2(DIV_B) : 1;
    localparam logic [AW-1:0] A_LAST = AW'(DIV_A - 1);
    localparam logic [BW-1:0] B_LAST = BW'(DIV_B - 1);

    typedef struct packed {
        logic [AW-1:0] a;
        logic [BW-1:0] b;
    } pace_t;

    pace_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (state_q.a == A_LAST) begin
            state_d.a = '0;
            state_d.b = (state_q.b == B_LAST) ? '0 : state_q.b + BW'(1);
        end else begin
            state_d.a = state_q.a + AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign tick = (state_q.a == A_LAST) && (state_q.b == B_LAST);

    AST_TICK_GAP:  assert property (@(posedge clk) disable iff (rst)
                       tick |=> !tick);                                   // R5
    AST_PRE_RANGE: assert property (@(posedge clk) disable iff (rst)
                       state_q.a <= A_LAST);                              // R5
endmodule

// File: rtl/dds_synth_rom.sv
module dds_synth_rom #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int HALF  = DEPTH / 2;
    localparam int QTR   = DEPTH / 4;
    localparam int AMP   = (1 << (DATA_W - 1)) - 1;
    localparam int FRAC  = 30;
    localparam int TERMS = 8;
    localparam longint PI_FX = 64'sd3373259426;
    localparam longint GUARD = 64'sd256;

    function automatic logic [DATA_W-1:0] cos_code(input int idx);
        longint one, x, x2, term, sum, scaled;
        int     q;
        logic   neg;
        one = 64'sd1 <<< FRAC;
        if (idx <= QTR) begin
            q = idx;            neg = 1'b0;
        end else if (idx <= HALF) begin
            q = HALF - idx;     neg = 1'b1;
        end else if (idx <= HALF + QTR) begin
            q = idx - HALF;     neg = 1'b1;
        end else begin
            q = DEPTH - idx;    neg = 1'b0;
        end
        x    = (longint'(q) * PI_FX) / longint'(HALF);
        x2   = (x * x) >>> FRAC;
        term = one;
        sum  = one;
        for (int k = 1; k <= TERMS; k++) begin
            term = -((term * x2) >>> FRAC) / longint'((2 * k - 1) * (2 * k));
            sum  = sum + term;
        end
        if (neg) sum = -sum;
        scaled = ((sum + one) * longint'(AMP) + GUARD) >>> FRAC;
        if (scaled < 0)                 scaled = 0;
        if (scaled > longint'(2 * AMP)) scaled = longint'(2 * AMP);
        return DATA_W'(scaled);
    endfunction

    logic [DATA_W-1:0] table_w [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        localparam logic [DATA_W-1:0] ENTRY = cos_code(g);
        assign table_w[g] = ENTRY;
    end

    assign data = table_w[addr];
endmodule

// File: rtl/dds_synth.sv
module dds_synth
    import dds_synth_pkg::*;
#(
    parameter int PHASE_W  = PHASE_BITS,
    parameter int SAMPLE_W = SAMPLE_BITS,
    parameter int DIV_A    = PRE_DIV,
    parameter int DIV_B    = POST_DIV
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tw_we,
    input  logic [PHASE_W-1:0]  tw_data,
    input  logic                saw_mode,
    input  logic                smp_req,
    output logic                smp_valid,
    output logic [SAMPLE_W-1:0] smp_data
);
    localparam int TOP_LO = PHASE_W - SAMPLE_W;

    typedef struct packed {
        logic [PHASE_W-1:0]  acc;
        logic [PHASE_W-1:0]  tw;
        logic [SAMPLE_W-1:0] sample;
        logic                valid;
    } dds_state_t;

    dds_state_t state_q, state_d;
    logic                tick;
    logic                step;
    logic [SAMPLE_W-1:0] phase_byte;
    logic [SAMPLE_W-1:0] rom_data;
    wave_t               wave;

    dds_synth_pacer #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_pacer (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    assign phase_byte = state_q.acc[PHASE_W-1:TOP_LO];

    dds_synth_rom #(.ADDR_W(SAMPLE_W), .DATA_W(SAMPLE_W)) u_rom (
        .addr (phase_byte),
        .data (rom_data)
    );

    assign wave = wave_t'(saw_mode);
    assign step = tick & smp_req;

    always_comb begin
        state_d       = state_q;
        state_d.valid = step;
        if (tw_we) state_d.tw = tw_data;
        if (step) begin
            state_d.acc    = state_q.acc + state_q.tw;
            state_d.sample = (wave == WAVE_SAW) ? phase_byte : rom_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign smp_valid = state_q.valid;
    assign smp_data  = state_q.sample;

    AST_VALID_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
                             smp_valid |-> $past(smp_req));                        // R6
    AST_DATA_HOLD:       assert property (@(posedge clk) disable iff (rst)
                             !smp_valid |-> $stable(smp_data));                    // R6
    AST_PHASE_HOLD:      assert property (@(posedge clk) disable iff (rst)
                             !smp_valid |-> $stable(state_q.acc));                 // R1
    AST_PHASE_STEP:      assert property (@(posedge clk) disable iff (rst)
                             smp_valid |-> state_q.acc == $past(state_q.acc) + $past(state_q.tw)); // R1
    AST_SAW_BYPASS:      assert property (@(posedge clk) disable iff (rst)
                             (smp_valid && $past(saw_mode)) |-> smp_data == $past(phase_byte)); // R4
    AST_VALID_PULSE:     assert property (@(posedge clk) disable iff (rst)
                             smp_valid |=> !smp_valid);                            // R5
endmodule

// File: tb/dds_synth_tb.sv
module dds_synth_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        tw_we;
    logic [31:0] tw_data;
    logic        saw_mode;
    logic        smp_req;
    logic        smp_valid;
    logic [7:0]  smp_data;

    always #10 clk = ~clk;

    dds_synth u_dut (
        .clk       (clk),
        .rst       (rst),
        .tw_we     (tw_we),
        .tw_data   (tw_data),
        .saw_mode  (saw_mode),
        .smp_req   (smp_req),
        .smp_valid (smp_valid),
        .smp_data  (smp_data)
    );

    int          n_checks = 0;
    int          n_fails  = 0;
    logic [7:0]  exp_q [$];
    string       tag_q [$];
    logic [31:0] m_acc;
    logic [31:0] m_tw;
    logic        m_saw;
    int          cyc = 0;
    int          last_cyc = -1;
    bit          req_run = 0;
    bit          done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] rom_ref(input int i);
        real v;
        v = ($cos(2.0 * 3.141592653589793 * i / 256.0) + 1.0) * 127.0;
        return 8'(int'($floor(v + 1.0e-6)));
    endfunction

    // driver: predicts each coming step from the phase model
    task automatic enqueue(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(m_saw ? m_acc[31:24] : rom_ref(int'(m_acc[31:24])));
            tag_q.push_back(tag);
            m_acc = m_acc + m_tw;
        end
    endtask

    task automatic drain();
        wait (exp_q.size() == 0);
        @(negedge clk);
    endtask

    task automatic set_tw(input logic [31:0] v);
        @(negedge clk);
        tw_we   = 1'b1;
        tw_data = v;
        @(negedge clk);
        tw_we   = 1'b0;
        m_tw    = v;
    endtask

    task automatic set_mode(input logic s);
        @(negedge clk);
        saw_mode = s;
        m_saw    = s;
    endtask

    // monitor: compares every produced sample with the queue head
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (!rst && smp_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6", "valid with no step expected", 1, 0);
                end else begin
                    logic [7:0] e;
                    string      t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(smp_data == e, t, "sample value", smp_data, e);
                end
                if (req_run && last_cyc >= 0)
                    chk(cyc - last_cyc == 18, "R5", "pulse spacing", cyc - last_cyc, 18);
                last_cyc = cyc;
                req_run  = 1'b1;
            end
            if (rst || !smp_req) begin
                req_run  = 1'b0;
                last_cyc = -1;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; tw_we = 1'b0; tw_data = '0; saw_mode = 1'b0; smp_req = 1'b1;
        m_acc = '0; m_tw = '0; m_saw = 1'b0;
        repeat (4) @(negedge clk);
        chk(smp_valid == 1'b0, "R8", "valid in reset", smp_valid, 0);
        chk(smp_data == 8'd0, "R8", "data in reset", smp_data, 0);

        // R10 / R9: zero tuning word, first sample is phase 0 -> 254
        enqueue(1, "R10");
        enqueue(2, "R9");
        rst = 1'b0;
        repeat (17) @(negedge clk);
        chk(smp_valid == 1'b0, "R5", "no pulse before edge 18", smp_valid, 0);
        @(negedge clk);
        chk(smp_valid == 1'b1, "R5", "first pulse at edge 18", smp_valid, 1);
        drain();

        // R7 / R2 / R3: one table entry per step, full sweep
        set_tw(32'h0100_0000);
        enqueue(1, "R7");
        enqueue(259, "R3");
        drain();

        // R2: index must come from the top byte
        set_tw(32'h00C0_0000);
        enqueue(20, "R2");
        drain();

        // R4 / R1: sawtooth with wrap
        set_mode(1'b1);
        set_tw(32'h1234_5679);
        enqueue(1, "R7");
        enqueue(40, "R4");
        drain();

        // R1: backwards wrap in sine mode
        set_mode(1'b0);
        set_tw(32'hFFFF_FFFF);
        enqueue(12, "R1");
        drain();
        set_tw(32'hF800_0000);
        enqueue(12, "R1");
        drain();

        // R6: stall with request low
        begin
            logic [7:0] held;
            bit         ok;
            held = smp_data;
            ok   = 1'b1;
            smp_req = 1'b0;
            repeat (60) begin
                @(negedge clk);
                if (smp_valid || smp_data != held) ok = 1'b0;
            end
            chk(ok, "R6", "output held during stall", smp_data, held);
            smp_req = 1'b1;
        end
        enqueue(4, "R6");
        drain();

        // R4: half-turn sawtooth alternates
        set_mode(1'b1);
        set_tw(32'h8000_0000);
        enqueue(6, "R4");
        drain();

        // R8: mid-run reset clears phase and tuning word
        set_mode(1'b0);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(smp_valid == 1'b0, "R8", "valid after mid reset", smp_valid, 0);
        chk(smp_data == 8'd0, "R8", "data after mid reset", smp_data, 0);
        m_acc = '0;
        m_tw  = '0;
        enqueue(2, "R8");
        rst = 1'b0;
        drain();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule